// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Rules

This block is the combinational arithmetic and logic core of a small accumulator-style processor. One operation select picks the operation. The inputs are the accumulator, a second 8-bit operand, the current flag byte and two 16-bit words. The block returns a 16-bit result and a new flag byte. The flag byte carries Zero, Subtract, Half-carry and Carry. Each operation has its own flag rule: a flag may be computed, forced to 0, forced to 1, kept from the incoming byte, or inverted.

The operations are the eight two-operand byte operations, increment and decrement of one operand, complement, set-carry, flip-carry and decimal adjust of the accumulator, a 16-bit word add, and a 16-bit plus signed-byte add. The surrounding core supplies the flag byte from its own register file and writes the outputs back. The core also handles decoding, sequencing and memory. An 8-bit result sits in the low byte of the result, and the high byte is zero.

Top module: `acc_alu`

## Requirements
- R1: The flag output holds Z in bit 7, N in bit 6, H in bit 5 and C in bit 4, and its bits 3..0 are always 0, whatever the flag input holds. For every 8-bit operation (select 0 to 13), result bits 15..8 are 0.
- R2: Select 0 (add) and select 1 (add with carry) put accumulator + operand (+ incoming C for select 1) in the result. Z is set when the byte is 0, N is 0, H is the carry out of bit 3 and C is the carry out of bit 7.
- R3: Select 2 (subtract), select 3 (subtract with borrow, which also takes away the incoming C) and select 7 (compare) compute accumulator - operand with N=1. H is the borrow into bit 4, C is the borrow out of bit 7, and Z is set on a zero difference. Compare returns the accumulator unchanged as its result.
- R4: Select 4 (AND) returns accumulator AND operand, with Z computed, N=0, H=1 and C=0.
- R5: Select 5 (XOR) and select 6 (OR) return the bitwise result, with Z computed and N, H and C all 0.
- R6: Select 8 (increment) and select 9 (decrement) act on the operand input. Z is computed. H is the carry out of bit 3 for increment and the borrow into bit 4 for decrement. N is 0 for increment and 1 for decrement. C is copied from the flag input.
- R7: Select 10 (complement) returns the inverted accumulator with N=1 and H=1, and keeps Z and C from the flag input.
- R8: Select 11 (set carry) and select 12 (flip carry) return the accumulator unchanged and give N=0, H=0 and keep Z. C is 1 for select 11 and the inverse of the incoming C for select 12.
- R9: Select 13 (decimal adjust) corrects the accumulator to packed BCD.
  - When the incoming N is 0, it adds 0x06 if H is set or the low nibble is above 9. It adds 0x60 and sets C if C is set or the accumulator is above 0x99.
  - When the incoming N is 1, it subtracts 0x06 when H is set and 0x60 when C is set, and C is kept.
  - Z is computed, H is 0 and N is kept.
- R10: Select 14 (word add) returns word A + word B over 16 bits. It keeps Z, gives N=0, takes H from the carry out of bit 11 and C from the carry out of bit 15.
- R11: Select 15 (word plus signed byte) returns word A + the sign-extended operand. It gives Z=0 and N=0. H and C are the carries out of bits 3 and 7 of the unsigned add of word A's low byte and the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation select, encoded as listed in the requirements |
| accIn | input | 8 | Accumulator value |
| operandIn | input | 8 | Second operand, increment/decrement target, or signed offset |
| flagsIn | input | 8 | Current flag byte (Z bit 7, N bit 6, H bit 5, C bit 4) |
| wordA | input | 16 | First word for the word adds (the stack pointer for select 15) |
| wordB | input | 16 | Second word for the word add |
| resultOut | output | 16 | Result; 8-bit results are zero-extended |
| flagsOut | output | 8 | New flag byte |

## Verification
The bench targets the carries at the nibble and byte boundaries: 0x3A+0xC6, 0xFF plus a carry in, 0x00 minus a borrow in, and 0x0FFF+1 for the word add. A design that took H from the wrong bit, or that ignored the carry or borrow in, gives a wrong H or C on exactly these values. Compare, increment and decrement are driven with noisy flag inputs, so a design that wrote back the difference or disturbed C is caught. Decimal adjust is exercised after adds and after subtracts, with and without H and C, because a mistake in the correction choice or in C handling shows up as a wrong BCD byte. The signed-offset add is given negative offsets, which catches an H or C taken from the 16-bit sum instead of the low byte.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int Z_BIT = 7;
  localparam int N_BIT = 6;
  localparam int H_BIT = 5;
  localparam int C_BIT = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADC  = 4'd1,  OP_SUB  = 4'd2,  OP_SBC  = 4'd3,
    OP_AND  = 4'd4,  OP_XOR  = 4'd5,  OP_OR   = 4'd6,  OP_CP   = 4'd7,
    OP_INC  = 4'd8,  OP_DEC  = 4'd9,  OP_CPL  = 4'd10, OP_SCF  = 4'd11,
    OP_CCF  = 4'd12, OP_DAA  = 4'd13, OP_WADD = 4'd14, OP_SPADD = 4'd15
  } aluOp_e;

  typedef enum logic [3:0] {
    U_ADDSUB, U_AND, U_XOR, U_OR, U_INCDEC, U_CPL, U_PASS, U_DAA, U_WORD, U_SPOFF
  } unitSel_e;

  typedef enum logic [2:0] {
    FR_CALC, FR_ZERO, FR_ONE, FR_KEEP, FR_FLIP
  } flagRule_e;

  typedef struct packed {
    unitSel_e  unit;
    logic      subtract;
    logic      useCarry;
    logic      keepAcc;
    flagRule_e zRule;
    flagRule_e nRule;
    flagRule_e hRule;
    flagRule_e cRule;
  } aluCtl_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  aluOp_e  op,
  output aluCtl_t ctl
);

  always_comb begin
    ctl = '{unit: U_PASS, subtract: 1'b0, useCarry: 1'b0, keepAcc: 1'b0,
            zRule: FR_KEEP, nRule: FR_KEEP, hRule: FR_KEEP, cRule: FR_KEEP};
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP: begin
        ctl.unit     = U_ADDSUB;
        ctl.subtract = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP);
        ctl.useCarry = (op == OP_ADC) || (op == OP_SBC);
        ctl.keepAcc  = (op == OP_CP);
        ctl.zRule    = FR_CALC;
        ctl.nRule    = ctl.subtract ? FR_ONE : FR_ZERO;
        ctl.hRule    = FR_CALC;
        ctl.cRule    = FR_CALC;
      end
      OP_AND: begin
        ctl.unit  = U_AND;
        ctl.zRule = FR_CALC; ctl.nRule = FR_ZERO; ctl.hRule = FR_ONE; ctl.cRule = FR_ZERO;
      end
      OP_XOR, OP_OR: begin
        ctl.unit  = (op == OP_XOR) ? U_XOR : U_OR;
        ctl.zRule = FR_CALC; ctl.nRule = FR_ZERO; ctl.hRule = FR_ZERO; ctl.cRule = FR_ZERO;
      end
      OP_INC, OP_DEC: begin
        ctl.unit     = U_INCDEC;
        ctl.subtract = (op == OP_DEC);
        ctl.zRule    = FR_CALC;
        ctl.nRule    = ctl.subtract ? FR_ONE : FR_ZERO;
        ctl.hRule    = FR_CALC;
        ctl.cRule    = FR_KEEP;
      end
      OP_CPL: begin
        ctl.unit  = U_CPL;
        ctl.nRule = FR_ONE; ctl.hRule = FR_ONE;
      end
      OP_SCF, OP_CCF: begin
        ctl.unit  = U_PASS;
        ctl.nRule = FR_ZERO; ctl.hRule = FR_ZERO;
        ctl.cRule = (op == OP_SCF) ? FR_ONE : FR_FLIP;
      end
      OP_DAA: begin
        ctl.unit  = U_DAA;
        ctl.zRule = FR_CALC; ctl.hRule = FR_ZERO; ctl.cRule = FR_CALC;
      end
      OP_WADD: begin
        ctl.unit  = U_WORD;
        ctl.nRule = FR_ZERO; ctl.hRule = FR_CALC; ctl.cRule = FR_CALC;
      end
      OP_SPADD: begin
        ctl.unit  = U_SPOFF;
        ctl.zRule = FR_ZERO; ctl.nRule = FR_ZERO; ctl.hRule = FR_CALC; ctl.cRule = FR_CALC;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluCtl_t             ctl,
  input  logic [DATA_W-1:0]   accIn,
  input  logic [DATA_W-1:0]   operandIn,
  input  logic [DATA_W-1:0]   flagsIn,
  input  logic [2*DATA_W-1:0] wordA,
  input  logic [2*DATA_W-1:0] wordB,
  output logic [2*DATA_W-1:0] resultOut,
  output logic                zCalc,
  output logic                hCalc,
  output logic                cCalc
);

  localparam int NIB    = DATA_W / 2;
  localparam int WIDE_W = 2 * DATA_W;
  localparam int HIGH_W = WIDE_W - NIB;

  localparam logic [DATA_W-1:0] LOW_FIX  = DATA_W'(6);
  localparam logic [DATA_W-1:0] HIGH_FIX = DATA_W'(6) << NIB;
  localparam logic [DATA_W-1:0] BCD_MAX  = DATA_W'(9) | (DATA_W'(9) << NIB);
  localparam logic [NIB-1:0]    NIB_MAX  = NIB'(9);

  logic                cin;
  logic [DATA_W:0]     byteFull;
  logic [NIB:0]        nibFull;
  logic [DATA_W-1:0]   calcVal;
  logic [DATA_W-1:0]   daaFix;
  logic [WIDE_W:0]     wordFull;
  logic [HIGH_W:0]     wordLowFull;
  logic [WIDE_W-1:0]   offsetExt;

  assign cin = ctl.useCarry & flagsIn[C_BIT];

  always_comb begin
    byteFull    = '0;
    nibFull     = '0;
    calcVal     = '0;
    daaFix      = '0;
    wordFull    = '0;
    wordLowFull = '0;
    offsetExt   = {{DATA_W{operandIn[DATA_W-1]}}, operandIn};
    resultOut   = '0;
    hCalc       = 1'b0;
    cCalc       = 1'b0;

    unique case (ctl.unit)
      U_ADDSUB: begin
        if (ctl.subtract) begin
          byteFull = {1'b0, accIn} - {1'b0, operandIn} - {{DATA_W{1'b0}}, cin};
          nibFull  = {1'b0, accIn[NIB-1:0]} - {1'b0, operandIn[NIB-1:0]} - {{NIB{1'b0}}, cin};
        end else begin
          byteFull = {1'b0, accIn} + {1'b0, operandIn} + {{DATA_W{1'b0}}, cin};
          nibFull  = {1'b0, accIn[NIB-1:0]} + {1'b0, operandIn[NIB-1:0]} + {{NIB{1'b0}}, cin};
        end
        calcVal   = byteFull[DATA_W-1:0];
        hCalc     = nibFull[NIB];
        cCalc     = byteFull[DATA_W];
        resultOut = {{DATA_W{1'b0}}, ctl.keepAcc ? accIn : calcVal};
      end
      U_AND, U_XOR, U_OR: begin
        calcVal   = (ctl.unit == U_AND) ? (accIn & operandIn) :
                    (ctl.unit == U_XOR) ? (accIn ^ operandIn) : (accIn | operandIn);
        resultOut = {{DATA_W{1'b0}}, calcVal};
      end
      U_INCDEC: begin
        if (ctl.subtract) begin
          calcVal = operandIn - DATA_W'(1);
          hCalc   = (operandIn[NIB-1:0] == '0);
        end else begin
          calcVal = operandIn + DATA_W'(1);
          hCalc   = (operandIn[NIB-1:0] == '1);
        end
        resultOut = {{DATA_W{1'b0}}, calcVal};
      end
      U_CPL: begin
        calcVal   = ~accIn;
        resultOut = {{DATA_W{1'b0}}, calcVal};
      end
      U_DAA: begin
        if (flagsIn[N_BIT]) begin
          daaFix  = (flagsIn[H_BIT] ? LOW_FIX : '0) | (flagsIn[C_BIT] ? HIGH_FIX : '0);
          calcVal = accIn - daaFix;
          cCalc   = flagsIn[C_BIT];
        end else begin
          daaFix  = ((flagsIn[H_BIT] || accIn[NIB-1:0] > NIB_MAX) ? LOW_FIX : '0) |
                    ((flagsIn[C_BIT] || accIn > BCD_MAX) ? HIGH_FIX : '0);
          calcVal = accIn + daaFix;
          cCalc   = flagsIn[C_BIT] || (accIn > BCD_MAX);
        end
        resultOut = {{DATA_W{1'b0}}, calcVal};
      end
      U_WORD: begin
        wordFull    = {1'b0, wordA} + {1'b0, wordB};
        wordLowFull = {1'b0, wordA[HIGH_W-1:0]} + {1'b0, wordB[HIGH_W-1:0]};
        hCalc       = wordLowFull[HIGH_W];
        cCalc       = wordFull[WIDE_W];
        resultOut   = wordFull[WIDE_W-1:0];
      end
      U_SPOFF: begin
        byteFull  = {1'b0, wordA[DATA_W-1:0]} + {1'b0, operandIn};
        nibFull   = {1'b0, wordA[NIB-1:0]} + {1'b0, operandIn[NIB-1:0]};
        hCalc     = nibFull[NIB];
        cCalc     = byteFull[DATA_W];
        resultOut = wordA + offsetExt;
      end
      default: begin
        resultOut = {{DATA_W{1'b0}}, accIn};
      end
    endcase
  end

  assign zCalc = (calcVal == '0);

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluCtl_t           ctl,
  input  logic [DATA_W-1:0] flagsIn,
  input  logic              zCalc,
  input  logic              hCalc,
  input  logic              cCalc,
  output logic [DATA_W-1:0] flagsOut
);

  function automatic logic applyRule(flagRule_e rule, logic calc, logic prev);
    unique case (rule)
      FR_CALC: applyRule = calc;
      FR_ZERO: applyRule = 1'b0;
      FR_ONE:  applyRule = 1'b1;
      FR_FLIP: applyRule = ~prev;
      default: applyRule = prev;
    endcase
  endfunction

  always_comb begin
    flagsOut        = '0;
    flagsOut[Z_BIT] = applyRule(ctl.zRule, zCalc, flagsIn[Z_BIT]);
    flagsOut[N_BIT] = applyRule(ctl.nRule, 1'b0, flagsIn[N_BIT]);
    flagsOut[H_BIT] = applyRule(ctl.hRule, hCalc, flagsIn[H_BIT]);
    flagsOut[C_BIT] = applyRule(ctl.cRule, cCalc, flagsIn[C_BIT]);
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]          opSel,
  input  logic [DATA_W-1:0]   accIn,
  input  logic [DATA_W-1:0]   operandIn,
  input  logic [DATA_W-1:0]   flagsIn,
  input  logic [2*DATA_W-1:0] wordA,
  input  logic [2*DATA_W-1:0] wordB,
  output logic [2*DATA_W-1:0] resultOut,
  output logic [DATA_W-1:0]   flagsOut
);

  aluOp_e  opCode;
  aluCtl_t ctl;
  logic    zCalc, hCalc, cCalc;

  assign opCode = aluOp_e'(opSel);

  acc_alu_ctrl u_ctrl (
    .op  (opCode),
    .ctl (ctl)
  );

  acc_alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .ctl       (ctl),
    .accIn     (accIn),
    .operandIn (operandIn),
    .flagsIn   (flagsIn),
    .wordA     (wordA),
    .wordB     (wordB),
    .resultOut (resultOut),
    .zCalc     (zCalc),
    .hCalc     (hCalc),
    .cCalc     (cCalc)
  );

  acc_alu_flags #(.DATA_W(DATA_W)) u_flags (
    .ctl      (ctl),
    .flagsIn  (flagsIn),
    .zCalc    (zCalc),
    .hCalc    (hCalc),
    .cCalc    (cCalc),
    .flagsOut (flagsOut)
  );

endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic [3:0]          opSel,
  input logic [DATA_W-1:0]   accIn,
  input logic [DATA_W-1:0]   flagsIn,
  input logic [2*DATA_W-1:0] resultOut,
  input logic [DATA_W-1:0]   flagsOut
);

  always_comb begin
    p_low_bits_zero_r1: assert (flagsOut[3:0] == 4'h0)
      else $error("low flag bits not zero");

    if (opSel == OP_CP)
      p_compare_keeps_acc_r3: assert (resultOut == {{DATA_W{1'b0}}, accIn} && flagsOut[N_BIT])
        else $error("compare changed accumulator or N");

    if (opSel == OP_AND)
      p_and_fixed_flags_r4: assert (flagsOut[H_BIT] && !flagsOut[N_BIT] && !flagsOut[C_BIT])
        else $error("AND fixed flags wrong");

    if (opSel == OP_INC || opSel == OP_DEC)
      p_step_keeps_carry_r6: assert (flagsOut[C_BIT] == flagsIn[C_BIT])
        else $error("increment/decrement changed C");

    if (opSel == OP_CPL)
      p_complement_keeps_zc_r7: assert (flagsOut[Z_BIT] == flagsIn[Z_BIT] &&
                                        flagsOut[C_BIT] == flagsIn[C_BIT])
        else $error("complement changed Z or C");

    if (opSel == OP_SCF || opSel == OP_CCF)
      p_carry_ops_keep_acc_r8: assert (resultOut == {{DATA_W{1'b0}}, accIn} &&
                                       flagsOut[Z_BIT] == flagsIn[Z_BIT])
        else $error("carry op changed accumulator or Z");

    if (opSel == OP_WADD)
      p_word_add_keeps_z_r10: assert (flagsOut[Z_BIT] == flagsIn[Z_BIT] && !flagsOut[N_BIT])
        else $error("word add Z or N wrong");

    if (opSel == OP_SPADD)
      p_offset_add_clears_zn_r11: assert (!flagsOut[Z_BIT] && !flagsOut[N_BIT])
        else $error("offset add Z or N not cleared");
  end

endmodule

bind acc_alu acc_alu_checker #(.DATA_W(DATA_W)) u_checker (
  .opSel     (opSel),
  .accIn     (accIn),
  .flagsIn   (flagsIn),
  .resultOut (resultOut),
  .flagsOut  (flagsOut)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opSel = '0;
  logic [7:0]  accIn = '0, operandIn = '0, flagsIn = '0;
  logic [15:0] wordA = '0, wordB = '0;
  logic [15:0] resultOut;
  logic [7:0]  flagsOut;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [15:0] expRes;
    logic [7:0]  expFlags;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  always #5 clk = ~clk;

  acc_alu dut (
    .opSel(opSel), .accIn(accIn), .operandIn(operandIn), .flagsIn(flagsIn),
    .wordA(wordA), .wordB(wordB), .resultOut(resultOut), .flagsOut(flagsOut)
  );

  task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] f, input logic [15:0] wa, input logic [15:0] wb,
                       input logic [15:0] er, input logic [7:0] ef, input string tag);
    expItem_t it;
    @(posedge clk);
    opSel = op; accIn = a; operandIn = b; flagsIn = f; wordA = wa; wordB = wb;
    it.expRes = er; it.expFlags = ef; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: compares at the falling edge after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (resultOut !== it.expRes || flagsOut !== it.expFlags) begin
          errors++;
          $display("FAIL %s: result=%h flags=%h expected result=%h flags=%h",
                   it.tag, resultOut, flagsOut, it.expRes, it.expFlags);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R1 and R2: add with noisy low flag bits; carries at bits 3 and 7
    drive(4'd0, 8'h3A, 8'hC6, 8'h0F, 16'h0, 16'h0, 16'h0000, 8'hB0, "R1 R2 add 3A+C6");
    drive(4'd0, 8'h12, 8'h34, 8'hF0, 16'h0, 16'h0, 16'h0046, 8'h00, "R2 add ignores carry in");
    drive(4'd1, 8'hE1, 8'h0F, 8'h10, 16'h0, 16'h0, 16'h00F1, 8'h20, "R2 adc half carry");
    drive(4'd1, 8'hFF, 8'h00, 8'h10, 16'h0, 16'h0, 16'h0000, 8'hB0, "R2 adc wrap");
    // R3: subtract, subtract with borrow, compare
    drive(4'd2, 8'h3E, 8'h3E, 8'h00, 16'h0, 16'h0, 16'h0000, 8'hC0, "R3 sub equal");
    drive(4'd2, 8'h3E, 8'h0F, 8'h00, 16'h0, 16'h0, 16'h002F, 8'h60, "R3 sub nibble borrow");
    drive(4'd3, 8'h3B, 8'h2A, 8'h10, 16'h0, 16'h0, 16'h0010, 8'h40, "R3 sbc borrow in");
    drive(4'd3, 8'h00, 8'h00, 8'h10, 16'h0, 16'h0, 16'h00FF, 8'h70, "R3 sbc underflow");
    drive(4'd7, 8'h3C, 8'h40, 8'h00, 16'h0, 16'h0, 16'h003C, 8'h50, "R3 compare keeps acc");
    // R4, R5: logic ops
    drive(4'd4, 8'h5A, 8'hA5, 8'hF0, 16'h0, 16'h0, 16'h0000, 8'hA0, "R4 and zero");
    drive(4'd4, 8'hF0, 8'h3C, 8'h00, 16'h0, 16'h0, 16'h0030, 8'h20, "R4 and nonzero");
    drive(4'd5, 8'hFF, 8'hFF, 8'h70, 16'h0, 16'h0, 16'h0000, 8'h80, "R5 xor zero");
    drive(4'd6, 8'h5A, 8'h00, 8'hF0, 16'h0, 16'h0, 16'h005A, 8'h00, "R5 or");
    // R6: increment / decrement of the operand, C kept
    drive(4'd8, 8'h99, 8'h0F, 8'h10, 16'h0, 16'h0, 16'h0010, 8'h30, "R6 inc half carry keeps C=1");
    drive(4'd8, 8'h99, 8'hFF, 8'h40, 16'h0, 16'h0, 16'h0000, 8'hA0, "R6 inc wrap keeps C=0");
    drive(4'd9, 8'h99, 8'h01, 8'h10, 16'h0, 16'h0, 16'h0000, 8'hD0, "R6 dec to zero");
    drive(4'd9, 8'h99, 8'h10, 8'h00, 16'h0, 16'h0, 16'h000F, 8'h60, "R6 dec nibble borrow");
    // R7: complement
    drive(4'd10, 8'h35, 8'h00, 8'h90, 16'h0, 16'h0, 16'h00CA, 8'hF0, "R7 cpl keeps Z C");
    drive(4'd10, 8'h00, 8'h00, 8'h00, 16'h0, 16'h0, 16'h00FF, 8'h60, "R7 cpl zero");
    // R8: carry ops
    drive(4'd11, 8'h77, 8'h00, 8'hE0, 16'h0, 16'h0, 16'h0077, 8'h90, "R8 set carry");
    drive(4'd12, 8'h77, 8'h00, 8'h90, 16'h0, 16'h0, 16'h0077, 8'h80, "R8 flip carry 1->0");
    drive(4'd12, 8'h77, 8'h00, 8'h00, 16'h0, 16'h0, 16'h0077, 8'h10, "R8 flip carry 0->1");
    // R9: decimal adjust
    drive(4'd13, 8'h3C, 8'h00, 8'h00, 16'h0, 16'h0, 16'h0042, 8'h00, "R9 adjust low nibble");
    drive(4'd13, 8'h9A, 8'h00, 8'h00, 16'h0, 16'h0, 16'h0000, 8'h90, "R9 adjust both to zero");
    drive(4'd13, 8'h11, 8'h00, 8'h20, 16'h0, 16'h0, 16'h0017, 8'h00, "R9 adjust on H");
    drive(4'd13, 8'h0F, 8'h00, 8'h60, 16'h0, 16'h0, 16'h0009, 8'h40, "R9 adjust after sub H");
    drive(4'd13, 8'hA0, 8'h00, 8'h50, 16'h0, 16'h0, 16'h0040, 8'h50, "R9 adjust after sub C");
    // R10: word add
    drive(4'd14, 8'h00, 8'h00, 8'hC0, 16'h0FFF, 16'h0001, 16'h1000, 8'hA0, "R10 word bit 11 carry");
    drive(4'd14, 8'h00, 8'h00, 8'h00, 16'h8000, 16'h8000, 16'h0000, 8'h10, "R10 word wrap keeps Z=0");
    // R11: word plus signed byte
    drive(4'd15, 8'h00, 8'h08, 8'hF0, 16'hFFF8, 16'h0, 16'h0000, 8'h30, "R11 offset carries");
    drive(4'd15, 8'h00, 8'hFF, 8'h00, 16'h1000, 16'h0, 16'h0FFF, 8'h00, "R11 offset minus one");
    drive(4'd15, 8'h00, 8'h80, 8'h00, 16'h00FF, 16'h0, 16'h007F, 8'h10, "R11 offset minus 128");
    while (expQ.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule